// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block is the control side of precise exceptions for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. The datapath is not part of it. It sees only a valid bit, a program counter and a fault code for each instruction. Fetch, decode and execute may each flag a fault against the instruction they hold. That code is not acted on where it is raised. It travels with the instruction in the stage registers until the instruction reaches the memory stage, which is the single commit point.

At the commit point the block looks at three things: the code carried by the instruction, any fault the memory stage raises itself, and the external interrupt request. If one of them calls for a trap, the block does the following in the same cycle:
- raises a redirect that steers fetch to the handler address;
- on the next clock edge, records the fault code and the faulting PC;
- clears every in-flight valid bit, including the one going to writeback;
- switches to supervisor mode and masks interrupts.

All older instructions have already left the memory stage, so they complete. The faulting instruction and every younger one are discarded. A return-from-trap input sets the machine back to user mode and unmasks interrupts.

Top module: `exc_commit_unit`

## Requirements
- R1: A fault code raised in fetch, decode or execute causes no trap until its instruction is valid in the memory stage. A trap is taken only while the memory stage holds a valid instruction, and `redirect_o` is high in exactly those cycles.
- R2: When one instruction collects several codes, the code raised in the earliest stage is the one recorded. The order is fetch, then decode, then execute, then memory.
- R3: An interrupt request is taken when the memory stage holds a valid instruction and interrupts are enabled. In that case the recorded code is the interrupt code (8), and it overrides any fault of that instruction. In any other cycle the request has no effect.
- R4: In the cycle after a trap, the decode, execute, memory and writeback valid bits are all low. The faulting instruction never reaches writeback, and the instruction presented at fetch in the trap cycle is discarded.
- R5: After a trap, `epc_o` holds the PC of the instruction that was in the memory stage. Every older instruction has reached writeback with its own PC.
- R6: After a trap, `cause_o` holds the 4-bit code that was taken. The codes are 1 for an instruction address fault, 2 for an illegal opcode, 3 for an overflow, 4 for a data address fault, 8 for an interrupt, and 0 for no fault.
- R7: A trap drives `redirect_pc_o` to the handler address in its cycle. On the following edge it sets `kernel_mode_o` to 1 and `irq_en_o` to 0.
- R8: A return-from-trap sets `kernel_mode_o` to 0 and `irq_en_o` to 1 on the next edge. If a trap happens in the same cycle, the trap takes precedence.
- R9: After reset, all valid bits are 0, `cause_o` and `epc_o` are 0, `kernel_mode_o` is 1 and `irq_en_o` is 0.
- R10: With no faults, an instruction presented at fetch appears in decode, execute, memory and writeback on the 1st, 2nd, 3rd and 4th following edges, and `wb_pc_o` carries its PC.
- R11: A fault code presented for a stage that holds no valid instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid_i | input | 1 | Fetch presents an instruction |
| f_pc_i | input | PC_W | PC of the fetched instruction |
| f_cause_i | input | CAUSE_W | Fault raised by fetch |
| d_cause_i | input | CAUSE_W | Fault raised by decode for the instruction it holds |
| x_cause_i | input | CAUSE_W | Fault raised by execute for the instruction it holds |
| m_cause_i | input | CAUSE_W | Fault raised by the memory stage for the instruction it holds |
| irq_i | input | 1 | External interrupt request |
| rfe_i | input | 1 | Return from trap |
| d_valid_o | output | 1 | Decode stage valid |
| x_valid_o | output | 1 | Execute stage valid |
| m_valid_o | output | 1 | Memory stage valid |
| wb_valid_o | output | 1 | Writeback stage valid (may write state) |
| wb_pc_o | output | PC_W | PC of the instruction in writeback |
| redirect_o | output | 1 | Trap taken this cycle; fetch restarts at the handler |
| redirect_pc_o | output | PC_W | Handler address |
| cause_o | output | CAUSE_W | Recorded trap code |
| epc_o | output | PC_W | Recorded faulting PC |
| kernel_mode_o | output | 1 | Supervisor mode |
| irq_en_o | output | 1 | Interrupts enabled |

## Verification
Suppose a stage register drops or corrupts a carried code. The fault then shows up one to three cycles later at the commit point as a missing `redirect_o`, or as a wrong `cause_o` on the edge after the trap. A bad kill shows as a valid bit still high on the edge after `redirect_o`, or as a faulting PC appearing on `wb_pc_o` one cycle later. The bench runs a behavioural model of the in-flight instructions and compares every output on every cycle, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/exc_pkg.sv
package exc_pkg;
   // Stages that hold an instruction ahead of the commit point (decode, execute, memory).
   localparam int unsigned N_QUEUED = 3;
   localparam int unsigned MIN_CAUSE_W = 4;
endpackage

// File: rtl/exc_pipe_stage.sv
module exc_pipe_stage #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill_i,
   input  logic               up_valid_i,
   input  logic [PC_W-1:0]    up_pc_i,
   input  logic [CAUSE_W-1:0] up_cause_i,
   input  logic [CAUSE_W-1:0] raise_i,
   output logic               valid_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [CAUSE_W-1:0] carried;

   // An older code already attached to the instruction wins over a new one.
   always_comb begin
      carried = '0;
      if (up_valid_i) begin
         carried = (up_cause_i != '0) ? up_cause_i : raise_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         pc_o    <= '0;
         cause_o <= '0;
      end else if (kill_i) begin
         valid_o <= 1'b0;
         pc_o    <= up_pc_i;
         cause_o <= '0;
      end else begin
         valid_o <= up_valid_i;
         pc_o    <= up_pc_i;
         cause_o <= carried;
      end
   end

   p_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> !valid_o);
   p_keep_earlier_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill_i && up_valid_i && up_cause_i != '0) |=> cause_o == $past(up_cause_i));
   p_empty_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_valid_i) |=> (!valid_o && cause_o == '0));
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb #(
   parameter int unsigned        CAUSE_W  = 4,
   parameter logic [CAUSE_W-1:0] IRQ_CODE = 4'd8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               m_valid_i,
   input  logic [CAUSE_W-1:0] m_carried_i,
   input  logic [CAUSE_W-1:0] m_local_i,
   input  logic               irq_i,
   input  logic               ie_i,
   output logic               take_o,
   output logic [CAUSE_W-1:0] code_o
);
   logic irq_hit;

   assign irq_hit = m_valid_i & ie_i & irq_i;

   always_comb begin
      code_o = '0;
      if (irq_hit) begin
         code_o = IRQ_CODE;
      end else if (m_valid_i) begin
         code_o = (m_carried_i != '0) ? m_carried_i : m_local_i;
      end
   end

   assign take_o = (code_o != '0);

   p_commit_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid_i |-> !take_o);
   p_irq_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_i && ie_i && irq_i) |-> (take_o && code_o == IRQ_CODE));
   p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_i && m_valid_i && m_carried_i == '0 && m_local_i == '0) |-> !take_o);
   p_mem_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_i && !irq_hit && m_carried_i != '0) |-> code_o == m_carried_i);
endmodule

// File: rtl/exc_ctrl_csr.sv
module exc_ctrl_csr #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [CAUSE_W-1:0] code_i,
   input  logic [PC_W-1:0]    fault_pc_i,
   input  logic               rfe_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [PC_W-1:0]    epc_o,
   output logic               kernel_o,
   output logic               ie_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_o  <= '0;
         epc_o    <= '0;
         kernel_o <= 1'b1;
         ie_o     <= 1'b0;
      end else if (take_i) begin
         cause_o  <= code_i;
         epc_o    <= fault_pc_i;
         kernel_o <= 1'b1;
         ie_o     <= 1'b0;
      end else if (rfe_i) begin
         kernel_o <= 1'b0;
         ie_o     <= 1'b1;
      end
   end

   p_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> epc_o == $past(fault_pc_i));
   p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> cause_o == $past(code_i));
   p_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (kernel_o && !ie_o));
   p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_i && !take_i) |=> (!kernel_o && ie_o));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rfe_i && !take_i) |=> ($stable(cause_o) && $stable(epc_o) && $stable(kernel_o)));
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_pkg::*;
#(
   parameter int unsigned        PC_W       = 32,
   parameter int unsigned        CAUSE_W    = 4,
   parameter logic [PC_W-1:0]    HANDLER_PC = 32'h0000_0080,
   parameter logic [CAUSE_W-1:0] IRQ_CODE   = 4'd8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               f_valid_i,
   input  logic [PC_W-1:0]    f_pc_i,
   input  logic [CAUSE_W-1:0] f_cause_i,
   input  logic [CAUSE_W-1:0] d_cause_i,
   input  logic [CAUSE_W-1:0] x_cause_i,
   input  logic [CAUSE_W-1:0] m_cause_i,
   input  logic               irq_i,
   input  logic               rfe_i,
   output logic               d_valid_o,
   output logic               x_valid_o,
   output logic               m_valid_o,
   output logic               wb_valid_o,
   output logic [PC_W-1:0]    wb_pc_o,
   output logic               redirect_o,
   output logic [PC_W-1:0]    redirect_pc_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [PC_W-1:0]    epc_o,
   output logic               kernel_mode_o,
   output logic               irq_en_o
);
   localparam int unsigned NQ = N_QUEUED;

   if (CAUSE_W < MIN_CAUSE_W) begin : g_bad_cause_w
      $error("CAUSE_W must be at least %0d", MIN_CAUSE_W);
   end
   if (PC_W < 2) begin : g_bad_pc_w
      $error("PC_W must be at least 2");
   end
   if (IRQ_CODE == '0) begin : g_bad_irq_code
      $error("IRQ_CODE must be non-zero");
   end
   if (NQ != 3) begin : g_bad_depth
      $error("stage fault inputs assume three queued stages");
   end

   // Index 0 is the fetch input; index k is the k-th stage register.
   logic [NQ:0]        sv;
   logic [PC_W-1:0]    spc [0:NQ];
   logic [CAUSE_W-1:0] sc  [0:NQ];
   logic [CAUSE_W-1:0] raise [0:NQ-1];
   logic               take;
   logic [CAUSE_W-1:0] code;
   logic               ie;
   logic               wv;
   logic [PC_W-1:0]    wpc;

   assign sv[0]    = f_valid_i;
   assign spc[0]   = f_pc_i;
   assign sc[0]    = '0;
   assign raise[0] = f_cause_i;
   assign raise[1] = d_cause_i;
   assign raise[2] = x_cause_i;

   for (genvar g = 0; g < NQ; g++) begin : g_stage
      exc_pipe_stage #(
         .PC_W    (PC_W),
         .CAUSE_W (CAUSE_W)
      ) u_stage (
         .clk        (clk),
         .rst_n      (rst_n),
         .kill_i     (take),
         .up_valid_i (sv[g]),
         .up_pc_i    (spc[g]),
         .up_cause_i (sc[g]),
         .raise_i    (raise[g]),
         .valid_o    (sv[g+1]),
         .pc_o       (spc[g+1]),
         .cause_o    (sc[g+1])
      );
   end

   exc_commit_arb #(
      .CAUSE_W  (CAUSE_W),
      .IRQ_CODE (IRQ_CODE)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_valid_i   (sv[NQ]),
      .m_carried_i (sc[NQ]),
      .m_local_i   (m_cause_i),
      .irq_i       (irq_i),
      .ie_i        (ie),
      .take_o      (take),
      .code_o      (code)
   );

   exc_ctrl_csr #(
      .PC_W    (PC_W),
      .CAUSE_W (CAUSE_W)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .code_i     (code),
      .fault_pc_i (spc[NQ]),
      .rfe_i      (rfe_i),
      .cause_o    (cause_o),
      .epc_o      (epc_o),
      .kernel_o   (kernel_mode_o),
      .ie_o       (ie)
   );

   // Writeback: the committing instruction passes only if it did not trap.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wv  <= 1'b0;
         wpc <= '0;
      end else begin
         wv  <= sv[NQ] & ~take;
         wpc <= spc[NQ];
      end
   end

   assign d_valid_o     = sv[1];
   assign x_valid_o     = sv[2];
   assign m_valid_o     = sv[NQ];
   assign wb_valid_o    = wv;
   assign wb_pc_o       = wpc;
   assign redirect_o    = take;
   assign redirect_pc_o = HANDLER_PC;
   assign irq_en_o      = ie;

   p_wb_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !wb_valid_o);
   p_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_o && !redirect_o) |=> (wb_valid_o && wb_pc_o == $past(spc[NQ])));
   p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> redirect_pc_o == HANDLER_PC);
endmodule

// File: tb/sim_exc_commit_unit.sv
`timescale 1ns/1ps
module sim_exc_commit_unit;
   localparam int unsigned PCW = 32;
   localparam int unsigned CW  = 4;
   localparam logic [31:0] HPC = 32'h0000_0080;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          f_valid_i = 1'b0;
   logic [31:0]   f_pc_i = '0;
   logic [3:0]    f_cause_i = '0, d_cause_i = '0, x_cause_i = '0, m_cause_i = '0;
   logic          irq_i = 1'b0, rfe_i = 1'b0;
   logic          d_valid_o, x_valid_o, m_valid_o, wb_valid_o, redirect_o;
   logic [31:0]   wb_pc_o, redirect_pc_o, epc_o;
   logic [3:0]    cause_o;
   logic          kernel_mode_o, irq_en_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   exc_commit_unit #(.PC_W(PCW), .CAUSE_W(CW), .HANDLER_PC(HPC), .IRQ_CODE(4'd8)) u0 (
      .clk(clk), .rst_n(rst_n), .f_valid_i(f_valid_i), .f_pc_i(f_pc_i),
      .f_cause_i(f_cause_i), .d_cause_i(d_cause_i), .x_cause_i(x_cause_i),
      .m_cause_i(m_cause_i), .irq_i(irq_i), .rfe_i(rfe_i),
      .d_valid_o(d_valid_o), .x_valid_o(x_valid_o), .m_valid_o(m_valid_o),
      .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o), .redirect_o(redirect_o),
      .redirect_pc_o(redirect_pc_o), .cause_o(cause_o), .epc_o(epc_o),
      .kernel_mode_o(kernel_mode_o), .irq_en_o(irq_en_o));

   // Reference model: in-flight instructions with their stage number (1=D .. 4=WB).
   typedef struct { int unsigned pc; int unsigned cs; int stg; } ins_t;
   ins_t        q[$];
   int unsigned r_cause = 0, r_epc = 0;
   bit          r_kern  = 1'b1, r_ie = 1'b0;

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int find(input int stg);
      foreach (q[i]) if (q[i].stg == stg) return i;
      return -1;
   endfunction

   task automatic step(input bit fv, input int unsigned fpc, input int unsigned fc,
                       input int unsigned dc, input int unsigned xc, input int unsigned mc,
                       input bit irq, input bit rfe);
      int          im, iw;
      int unsigned code;
      bit          tk;
      ins_t        nq[$];
      @(negedge clk);
      f_valid_i = fv; f_pc_i = fpc; f_cause_i = fc[3:0];
      d_cause_i = dc[3:0]; x_cause_i = xc[3:0]; m_cause_i = mc[3:0];
      irq_i = irq; rfe_i = rfe;
      #1;
      im = find(3);
      iw = find(4);
      code = 0;
      if (im >= 0) code = (irq && r_ie) ? 8 : ((q[im].cs != 0) ? q[im].cs : mc);
      tk = (code != 0);
      chk("R1 redirect", redirect_o, tk);
      if (tk) chk("R7 handler pc", redirect_pc_o, HPC);
      chk("R10 decode valid", d_valid_o, find(1) >= 0);
      chk("R10 execute valid", x_valid_o, find(2) >= 0);
      chk("R10 memory valid", m_valid_o, im >= 0);
      chk("R4 writeback valid", wb_valid_o, iw >= 0);
      if (iw >= 0) chk("R5 writeback pc", wb_pc_o, q[iw].pc);
      chk("R6 cause", cause_o, r_cause);
      chk("R5 epc", epc_o, r_epc);
      chk("R7 kernel", kernel_mode_o, r_kern);
      chk("R8 irq enable", irq_en_o, r_ie);
      // advance model to the next edge
      if (tk) begin
         r_cause = code; r_epc = q[im].pc; r_kern = 1'b1; r_ie = 1'b0;
         q.delete();
      end else begin
         if (rfe) begin r_kern = 1'b0; r_ie = 1'b1; end
         foreach (q[i]) begin
            ins_t e = q[i];
            if (e.stg != 4) begin
               if (e.stg == 1 && e.cs == 0) e.cs = dc;
               if (e.stg == 2 && e.cs == 0) e.cs = xc;
               e.stg++;
               nq.push_back(e);
            end
         end
         if (fv) nq.push_back('{pc: fpc, cs: fc, stg: 1});
         q = nq;
      end
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic ret();  step(0, 0, 0, 0, 0, 0, 0, 1); endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R9 reset state
      idle();
      chk("R9 kernel after reset", kernel_mode_o, 1);
      chk("R9 irq enable after reset", irq_en_o, 0);
      chk("R9 cause after reset", cause_o, 0);
      chk("R9 wb valid after reset", wb_valid_o, 0);
      // R8 return to user mode
      ret(); idle();
      chk("R8 user mode", kernel_mode_o, 0);
      // R10 plain stream, R5 data fault on the fifth instruction
      for (int i = 0; i < 12; i++)
         step(i < 10, 32'h1000 + 4*i, 0, 0, 0, (i == 7) ? 4 : 0, 0, 0);
      idle();
      chk("R5 epc of data fault", epc_o, 32'h1010);
      chk("R6 data fault code", cause_o, 4);
      // R2 decode code beats execute and memory codes
      ret();
      step(1, 32'h200, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 2, 0, 0, 0, 0);
      step(0, 0, 0, 0, 3, 0, 0, 0);
      step(0, 0, 0, 0, 0, 4, 0, 0);
      idle();
      chk("R2 earliest code", cause_o, 2);
      // R6 overflow alone
      step(1, 32'h240, 0, 0, 0, 0, 0, 0);
      idle();
      step(0, 0, 0, 0, 3, 0, 0, 0);
      idle(); idle();
      chk("R6 overflow code", cause_o, 3);
      // R3 interrupt masked while in kernel mode
      step(1, 32'h280, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      idle();
      chk("R3 masked irq leaves cause", cause_o, 3);
      // R3 interrupt with empty memory stage
      ret();
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      chk("R3 irq without instruction", kernel_mode_o, 0);
      // R3 interrupt overrides a fetch fault
      step(1, 32'h300, 1, 0, 0, 0, 0, 0);
      idle(); idle();
      step(1, 32'h304, 0, 0, 0, 0, 1, 0);
      idle();
      chk("R3 irq code", cause_o, 8);
      chk("R3 irq epc", epc_o, 32'h300);
      chk("R4 fetch in trap cycle dropped", d_valid_o, 0);
      // R8 trap wins over simultaneous return
      ret();
      step(1, 32'h400, 1, 0, 0, 0, 0, 0);
      idle(); idle();
      ret();
      idle();
      chk("R8 trap beats return", kernel_mode_o, 1);
      chk("R6 fetch fault code", cause_o, 1);
      // R11 codes on empty stages
      ret();
      step(0, 0, 0, 2, 3, 4, 0, 0);
      step(0, 0, 0, 2, 3, 4, 0, 0);
      idle();
      chk("R11 no trap on empty stages", kernel_mode_o, 0);
      // R1 mixed stream with decode faults on every other cycle
      for (int i = 0; i < 16; i++)
         step(1, 32'h2000 + 4*i, 0, (i % 2 == 1) ? 2 : 0, 0, 0, 0, (i % 5 == 4));
      repeat (4) idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule